// File: doc/BRIEF.md
# Object-to-Cache-Line Request Splitter

This block sits between a core's pre-execution request path and the memory controller's backend operation engines. A pre-execution request arrives at object granularity: a start byte address, a byte count, a request kind, and a set of tracking tags. The tags are a pre-execution ID, a thread ID and a transaction ID. The block cuts that object into one request per 64-byte cache line it touches. The requests leave one per cycle over a valid/ready handshake, in ascending address order.

Each outgoing request carries the line-aligned address and a 64-bit byte-enable mask that marks the bytes of that line covered by the object. It also carries the parent's kind and tags unchanged, so that results computed ahead of time can later be matched against the real write. A final-piece flag marks the last request of each object. An object of zero bytes is accepted and produces nothing. While pieces of an object are still pending, no new object is taken.

Top module: `obj_split`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted object of size S>0 at address A yields exactly ((A+S-1)>>6)-(A>>6)+1 output requests, one for each 64-byte line it touches.
- R3: Output requests come out in ascending line order, each line 64 above the previous one. `out_addr` is the line base (bits 5:0 zero) of the line containing the covered bytes.
- R4: Bit i of `out_mask` is 1 exactly when byte (out_addr+i) lies in [A, A+S-1]. Bit 0 is the lowest byte of the line.
- R5: `out_kind`, `out_pid`, `out_tid` and `out_xid` equal the parent's values on every request. The kind encoding is 1 = address-dependent, 2 = data-dependent, 3 = both-dependent.
- R6: `out_last` is 1 on the final request of an object and 0 on all the others.
- R7: An object with size 0 completes its input handshake in the cycle it is offered and produces no output request. `in_ready` is 1 again in the next cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output stays valid and all output fields hold their values.
- R9: The first request is valid in the cycle after acceptance. `in_ready` is 0 from then until the cycle after the last request has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Object request offered |
| in_ready | output | 1 | Block can take an object |
| in_addr | input | ADDR_W | Start byte address of object |
| in_size | input | SIZE_W | Object length in bytes |
| in_kind | input | 2 | Request kind (1 addr, 2 data, 3 both) |
| in_pid | input | PID_W | Pre-execution ID |
| in_tid | input | TID_W | Thread ID |
| in_xid | input | XID_W | Transaction ID |
| out_valid | output | 1 | Line request valid |
| out_ready | input | 1 | Downstream takes line request |
| out_addr | output | ADDR_W | Line-aligned address |
| out_mask | output | LINE_BYTES | Byte-enable mask of covered bytes |
| out_kind | output | 2 | Copied kind |
| out_pid | output | PID_W | Copied pre-execution ID |
| out_tid | output | TID_W | Copied thread ID |
| out_xid | output | XID_W | Copied transaction ID |
| out_last | output | 1 | Final line request of the object |

## Verification
The hardest situation to reach is a middle or final line request that is held under backpressure exactly when the mask boundaries are at their extremes. Examples are an object ending on byte 63 or starting on byte 0, where an off-by-one in the end line or the mask would hide behind a correct-looking count. The stimulus sweeps every start offset in a line against sizes placed around one and two line lengths. Meanwhile a pseudo-random ready pattern withholds acceptance on about a quarter of the cycles, so stalls land on first, middle and last pieces alike.

// File: rtl/obj_split_pkg.sv
package obj_split_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2,
    KIND_BOTH = 2'd3
  } pre_kind_e;
endpackage

// File: rtl/obj_split_mask.sv
module obj_split_mask #(
  parameter int LINE_BYTES = 64,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic [OFF_W-1:0]      lo,
  input  logic [OFF_W-1:0]      hi,
  output logic [LINE_BYTES-1:0] mask
);
  // one enable bit per byte lane, set inside the inclusive window [lo, hi]
  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
    assign mask[i] = (OFF_W'(i) >= lo) && (OFF_W'(i) <= hi);
  end
endmodule

// File: rtl/obj_split_seg.sv
module obj_split_seg #(
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic [ADDR_W-1:0] seg_start,
  input  logic [ADDR_W-1:0] seg_end,
  output logic [ADDR_W-1:0] line_base,
  output logic [OFF_W-1:0]  lo,
  output logic [OFF_W-1:0]  hi,
  output logic              last
);
  assign line_base = {seg_start[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign lo        = seg_start[OFF_W-1:0];
  assign last      = (seg_start[ADDR_W-1:OFF_W] == seg_end[ADDR_W-1:OFF_W]);
  assign hi        = last ? seg_end[OFF_W-1:0] : {OFF_W{1'b1}};
endmodule

// File: rtl/obj_split.sv
module obj_split
  import obj_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int LINE_BYTES = 64,
  parameter int PID_W      = 8,
  parameter int TID_W      = 4,
  parameter int XID_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [ADDR_W-1:0]     in_addr,
  input  logic [SIZE_W-1:0]     in_size,
  input  logic [1:0]            in_kind,
  input  logic [PID_W-1:0]      in_pid,
  input  logic [TID_W-1:0]      in_tid,
  input  logic [XID_W-1:0]      in_xid,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ADDR_W-1:0]     out_addr,
  output logic [LINE_BYTES-1:0] out_mask,
  output logic [1:0]            out_kind,
  output logic [PID_W-1:0]      out_pid,
  output logic [TID_W-1:0]      out_tid,
  output logic [XID_W-1:0]      out_xid,
  output logic                  out_last
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic              accept, advance;
  logic [ADDR_W-1:0] end_r;
  logic [ADDR_W-1:0] seg_start, seg_end, seg_base;
  logic [OFF_W-1:0]  seg_lo, seg_hi;
  logic              seg_last;
  logic [LINE_BYTES-1:0] seg_mask;

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;
  assign advance  = out_valid && out_ready && !out_last;

  // the next piece starts either at the new object or at the following line
  always_comb begin
    if (accept) begin
      seg_start = in_addr;
      seg_end   = in_addr + ADDR_W'(in_size) - ADDR_W'(1);
    end else begin
      seg_start = out_addr + ADDR_W'(LINE_BYTES);
      seg_end   = end_r;
    end
  end

  obj_split_seg #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_seg (
    .seg_start(seg_start), .seg_end(seg_end),
    .line_base(seg_base), .lo(seg_lo), .hi(seg_hi), .last(seg_last)
  );

  obj_split_mask #(.LINE_BYTES(LINE_BYTES)) u_mask (
    .lo(seg_lo), .hi(seg_hi), .mask(seg_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_mask  <= '0;
      out_last  <= 1'b0;
      out_kind  <= 2'(KIND_NONE);
      out_pid   <= '0;
      out_tid   <= '0;
      out_xid   <= '0;
      end_r     <= '0;
    end else if (accept) begin
      if (in_size != '0) begin
        out_valid <= 1'b1;
        out_addr  <= seg_base;
        out_mask  <= seg_mask;
        out_last  <= seg_last;
        end_r     <= seg_end;
        out_kind  <= in_kind;
        out_pid   <= in_pid;
        out_tid   <= in_tid;
        out_xid   <= in_xid;
      end
    end else if (advance) begin
      out_addr <= seg_base;
      out_mask <= seg_mask;
      out_last <= seg_last;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled piece keeps every field
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_mask)
      && $stable(out_last) && $stable(out_kind) && $stable(out_pid));

  // R3: pieces step up by one line
  a_r3_ascend: assert property (@(posedge clk) disable iff (rst)
    advance |=> out_valid && (out_addr == $past(out_addr) + ADDR_W'(LINE_BYTES)));

  // R5: tags do not change within one object
  a_r5_tags_kept: assert property (@(posedge clk) disable iff (rst)
    advance |=> (out_kind == $past(out_kind)) && (out_tid == $past(out_tid))
      && (out_xid == $past(out_xid)));

  // R6: the flagged piece ends the object
  a_r6_last_ends: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid);

  // R4: a non-final piece runs to the top byte, a follow-on piece starts at byte 0
  a_r4_mask_top: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |-> out_mask[LINE_BYTES-1]);
  a_r4_mask_bottom: assert property (@(posedge clk) disable iff (rst)
    advance |=> out_mask[0]);

  // R9: no object is taken while a piece is pending
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    out_valid && !(out_ready && out_last) |=> !in_ready);
endmodule

// File: tb/obj_split_tb.sv
module obj_split_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, SIZE_W = 16, LB = 64, PID_W = 8, TID_W = 4, XID_W = 8;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [SIZE_W-1:0] in_size = '0;
  logic [1:0] in_kind = '0;
  logic [PID_W-1:0] in_pid = '0;
  logic [TID_W-1:0] in_tid = '0;
  logic [XID_W-1:0] in_xid = '0;
  logic out_valid, out_ready = 0, out_last;
  logic [ADDR_W-1:0] out_addr;
  logic [LB-1:0] out_mask;
  logic [1:0] out_kind;
  logic [PID_W-1:0] out_pid;
  logic [TID_W-1:0] out_tid;
  logic [XID_W-1:0] out_xid;

  int tests = 0, fails = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  obj_split u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_mask(input int lo, input int hi);
    logic [63:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  // offers one object and consumes all its pieces with random stalls
  task automatic run_obj(input logic [31:0] a, input int s, input logic [1:0] k,
                         input logic [7:0] p, input logic [3:0] t, input logic [7:0] x,
                         input bit stall);
    logic [31:0] e;
    int first_line, n, j, lo, hi;
    bit held;
    logic [31:0] h_addr;
    logic [63:0] h_mask;
    e = a + 32'(s) - 1;
    first_line = int'(a >> 6);
    n = (s == 0) ? 0 : int'(e >> 6) - first_line + 1;
    @(negedge clk);
    in_valid = 1; in_addr = a; in_size = 16'(s); in_kind = k; in_pid = p; in_tid = t; in_xid = x;
    out_ready = 0;
    chk(in_ready == 1, "R9 idle in_ready", 64'(in_ready), 1);
    @(negedge clk);
    in_valid = 0;
    if (n == 0) begin
      chk(out_valid == 0, "R7 zero-size no output", 64'(out_valid), 0);
      chk(in_ready == 1, "R7 zero-size ready again", 64'(in_ready), 1);
      return;
    end
    chk(in_ready == 0, "R9 busy in_ready", 64'(in_ready), 0);
    j = 0; held = 0; h_addr = '0; h_mask = '0;
    while (j < n) begin
      lo = (j == 0) ? int'(a[5:0]) : 0;
      hi = (j == n - 1) ? int'(e[5:0]) : 63;
      chk(out_valid == 1, "R2 piece present", 64'(out_valid), 1);
      chk(out_addr == 32'((first_line + j) << 6), "R3 line address", 64'(out_addr), 64'((first_line + j) << 6));
      chk(out_mask == exp_mask(lo, hi), "R4 byte mask", out_mask, exp_mask(lo, hi));
      chk({out_kind, out_pid, out_tid, out_xid} == {k, p, t, x}, "R5 kind and tags",
          64'({out_kind, out_pid, out_tid, out_xid}), 64'({k, p, t, x}));
      chk(out_last == (j == n - 1), "R6 last flag", 64'(out_last), 64'(j == n - 1));
      if (held) chk(out_addr == h_addr && out_mask == h_mask, "R8 hold under stall", 64'(out_addr), 64'(h_addr));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      held = !out_ready; h_addr = out_addr; h_mask = out_mask;
      if (out_ready) j++;
      @(negedge clk);
    end
    out_ready = 0;
    chk(out_valid == 0, "R2 no extra piece", 64'(out_valid), 0);
    chk(in_ready == 1, "R9 ready after last", 64'(in_ready), 1);
  endtask

  initial begin
    int sizes[9] = '{1, 2, 63, 64, 65, 127, 128, 129, 200};
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", 64'(out_valid), 0);
    chk(in_ready == 1, "R1 reset in_ready", 64'(in_ready), 1);
    rst = 0;
    @(negedge clk);
    for (int off = 0; off < 64; off++) begin
      for (int si = 0; si < 9; si++) begin
        run_obj(32'h0001_0000 + 32'(off) + 32'((off * 9 + si) << 8), sizes[si],
                2'(1 + (off + si) % 3), 8'(off * 3 + si), 4'(si), 8'(off), (off % 8) != 0);
      end
    end
    run_obj(32'h2000_0010, 0, 2'd1, 8'h11, 4'h2, 8'h33, 1);
    run_obj(32'h2000_003F, 0, 2'd3, 8'h44, 4'h5, 8'h66, 0);
    run_obj(32'h3000_0000, 64, 2'd2, 8'hA5, 4'hF, 8'h5A, 1);
    run_obj(32'h3000_003F, 2, 2'd3, 8'h01, 4'h1, 8'h02, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule